// File: doc/BRIEF.md
# Packed Floor-Rounding Float-to-Integer Converter

This block takes a packed vector of IEEE floating-point lanes and turns every lane into an integer of the same width. It always rounds toward minus infinity and ignores any global rounding-mode setting. Lanes are either 16-bit half precision or 32-bit single precision. The source covers one 64-bit register, or two adjacent 64-bit registers when the wide select is set. Each result lands in the same bit position as its source lane. A separate select chooses signed or unsigned results.

The converter sits behind a valid/ready stream on both sides. An operation is accepted on a clock edge where `in_valid` and `in_ready` are both high. Its result is held in a single output register until the consumer takes it on an edge where `out_valid` and `out_ready` are both high. `in_ready` is high whenever that register is empty or is being drained in the same cycle. A stalled consumer therefore stalls the producer without losing data. Illegal encodings are not rejected at the interface. They are accepted and come back as a result with the undefined flag set.

Top module: `pfc_floor_top`

## Requirements
- R1: Every active lane gives the largest integer not above the lane's value (floor). For example, half 1.5 (0x3E00) gives 1, -1.5 (0xBE00) gives -2, and -0.5 (0xB800) gives -1 when the result is signed.
- R2: Size code 2'b01 selects 16-bit half lanes and 2'b10 selects 32-bit single lanes. Lane e of the vector occupies bits [e*W +: W], where W is the lane width. Its result is written to the same bits.
- R3: The undefined flag is set, and the output vector and both other flags are zero, in any of these cases: the size code is 2'b00 or 2'b11; the size code is 2'b01 while `half_ok` is low; `in_wide` is high and bit 0 of either `in_dst_idx` or `in_src_idx` is 1.
- R4: With `in_uns`=0 the results are two's-complement signed. With `in_uns`=1 they are unsigned.
- R5: A value whose floor lies outside the result range saturates to the nearest limit: signed [-2^(W-1), 2^(W-1)-1], unsigned [0, 2^W-1]. Infinities saturate the same way. Any saturation sets `out_invalid`.
- R6: A NaN lane gives 0 and sets `out_invalid`.
- R7: Zero and denormal lanes (exponent field 0) give 0 and set no flag.
- R8: `out_inexact` is set when some active lane that did not saturate had a nonzero fraction discarded. It stays clear when every active lane converts exactly.
- R9: With `in_wide`=0 only bits [63:0] are converted and bits [127:64] of the result are zero. With `in_wide`=1 all 128 bits are converted.
- R10: `in_ready` equals `!out_valid || out_ready`. A result is valid on the edge after its acceptance. While `out_valid` is high and `out_ready` is low, the result and its flags stay unchanged.
- R11: During and just after reset `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| half_ok | input | 1 | Static: half-precision lanes are supported |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation can be taken this cycle |
| in_vec | input | 128 | Packed floating-point source |
| in_size | input | 2 | Element size code |
| in_uns | input | 1 | 1 = unsigned results |
| in_wide | input | 1 | 1 = two registers (128 bits) |
| in_dst_idx | input | 5 | Destination register index (alignment check only) |
| in_src_idx | input | 5 | Source register index (alignment check only) |
| out_valid | output | 1 | Result held |
| out_ready | input | 1 | Consumer takes the result |
| out_vec | output | 128 | Packed integer result |
| out_undef | output | 1 | Illegal encoding |
| out_invalid | output | 1 | Some lane saturated or was NaN |
| out_inexact | output | 1 | Some lane discarded a fraction |

## Verification
Every result becomes visible exactly one clock edge after the edge that accepts its operation. It stays visible for as long as the consumer withholds `out_ready`. The bench settles its inputs just after each falling edge. It then works out which transfers the next rising edge will make. Each accepted operation is pushed to a queue of expected results, computed with real arithmetic and `$floor`. The value on the output port is compared with the head of that queue exactly when a transfer is due. Because the consumer's ready is randomly withheld, results are also compared after stalls of several cycles.

// File: rtl/pfc_pkg.sv
package pfc_pkg;
  typedef enum logic [1:0] {
    SZ_RSV_LO = 2'b00,
    SZ_HALF   = 2'b01,
    SZ_SINGLE = 2'b10,
    SZ_RSV_HI = 2'b11
  } elem_size_e;

  localparam int unsigned HALF_W   = 16;
  localparam int unsigned HALF_EW  = 5;
  localparam int unsigned HALF_MW  = 10;
  localparam int unsigned SINGLE_W = 32;
  localparam int unsigned SINGLE_EW = 8;
  localparam int unsigned SINGLE_MW = 23;
endpackage

// File: rtl/pfc_decode.sv
module pfc_decode
  import pfc_pkg::*;
#(
  parameter int unsigned IDX_W = 5
) (
  input  logic [1:0]       size,
  input  logic             half_ok,
  input  logic             wide,
  input  logic [IDX_W-1:0] dst_idx,
  input  logic [IDX_W-1:0] src_idx,
  output logic             undef,
  output logic             is_half
);
  logic bad_size;
  logic bad_pair;

  always_comb begin
    bad_size = 1'b0;
    is_half  = 1'b0;
    case (elem_size_e'(size))
      SZ_HALF: begin
        is_half  = 1'b1;
        bad_size = !half_ok;
      end
      SZ_SINGLE: bad_size = 1'b0;
      default:   bad_size = 1'b1;
    endcase
    bad_pair = wide && (dst_idx[0] || src_idx[0]);
    undef    = bad_size || bad_pair;
  end
endmodule

// File: rtl/pfc_lane.sv
module pfc_lane #(
  parameter int unsigned IW = 16,
  parameter int unsigned EW = 5,
  parameter int unsigned MW = 10
) (
  input  logic [IW-1:0] fp,
  input  logic          en,
  input  logic          uns,
  output logic [IW-1:0] res,
  output logic          inv,
  output logic          inx
);
  localparam int unsigned BIAS = (1 << (EW - 1)) - 1;
  localparam int unsigned FW   = IW + MW + 1;
  localparam logic [EW-1:0] EXP_ALL = '1;
  localparam logic [IW:0] NEG_LIM = (IW + 1)'(1) << (IW - 1);
  localparam logic [IW-1:0] S_MAX = {1'b0, {(IW - 1){1'b1}}};
  localparam logic [IW-1:0] S_MIN = {1'b1, {(IW - 1){1'b0}}};

  logic                sgn;
  logic [EW-1:0]       ex;
  logic [MW-1:0]       man;
  logic signed [EW+1:0] ue;
  logic [EW+1:0]       shamt;
  logic [FW-1:0]       fix;
  logic [IW:0]         imag;
  logic [IW:0]         fmag;
  logic                frac;
  logic                big;

  always_comb begin
    sgn   = fp[IW-1];
    ex    = fp[IW-2 -: EW];
    man   = fp[MW-1:0];
    ue    = $signed({2'b00, ex}) - $signed((EW + 2)'(BIAS));
    shamt = ue;
    fix   = '0;
    big   = 1'b0;
    frac  = 1'b0;
    if (ue >= $signed((EW + 2)'(IW))) begin
      big = 1'b1;
    end else if (!ue[EW+1]) begin
      fix = FW'({1'b1, man}) << shamt;
    end else begin
      frac = 1'b1;
    end
    imag = fix[FW-1:MW];
    frac = frac || (|fix[MW-1:0]);
    fmag = imag + (IW + 1)'(sgn && frac);

    res = '0;
    inv = 1'b0;
    inx = 1'b0;
    if (!en) begin
      res = '0;
    end else if (ex == EXP_ALL) begin
      inv = 1'b1;
      if (man == '0) begin
        if (uns) res = sgn ? '0 : '1;
        else     res = sgn ? S_MIN : S_MAX;
      end
    end else if (ex == '0) begin
      res = '0;
    end else if (uns) begin
      if (sgn) begin
        inv = 1'b1;
      end else if (big || imag[IW]) begin
        inv = 1'b1;
        res = '1;
      end else begin
        res = imag[IW-1:0];
        inx = frac;
      end
    end else if (!sgn) begin
      if (big || imag[IW] || imag[IW-1]) begin
        inv = 1'b1;
        res = S_MAX;
      end else begin
        res = imag[IW-1:0];
        inx = frac;
      end
    end else begin
      if (big || (fmag > NEG_LIM)) begin
        inv = 1'b1;
        res = S_MIN;
      end else begin
        res = -fmag[IW-1:0];
        inx = frac;
      end
    end
  end
endmodule

// File: rtl/pfc_lane_array.sv
module pfc_lane_array #(
  parameter int unsigned IW = 16,
  parameter int unsigned EW = 5,
  parameter int unsigned MW = 10,
  parameter int unsigned NL = 8
) (
  input  logic [NL*IW-1:0] src,
  input  logic [NL-1:0]    en,
  input  logic             uns,
  output logic [NL*IW-1:0] dst,
  output logic             inv,
  output logic             inx
);
  logic [NL-1:0] inv_l;
  logic [NL-1:0] inx_l;

  for (genvar i = 0; i < NL; i++) begin : g_lane
    pfc_lane #(.IW(IW), .EW(EW), .MW(MW)) u_lane (
      .fp  (src[i*IW +: IW]),
      .en  (en[i]),
      .uns (uns),
      .res (dst[i*IW +: IW]),
      .inv (inv_l[i]),
      .inx (inx_l[i])
    );
  end

  assign inv = |inv_l;
  assign inx = |inx_l;
endmodule

// File: rtl/pfc_floor_top.sv
module pfc_floor_top
  import pfc_pkg::*;
#(
  parameter int unsigned REG_W = 64,
  parameter int unsigned IDX_W = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 half_ok,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [2*REG_W-1:0]   in_vec,
  input  logic [1:0]           in_size,
  input  logic                 in_uns,
  input  logic                 in_wide,
  input  logic [IDX_W-1:0]     in_dst_idx,
  input  logic [IDX_W-1:0]     in_src_idx,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [2*REG_W-1:0]   out_vec,
  output logic                 out_undef,
  output logic                 out_invalid,
  output logic                 out_inexact
);
  localparam int unsigned VEC_W = 2 * REG_W;
  localparam int unsigned NL16  = VEC_W / HALF_W;
  localparam int unsigned NL32  = VEC_W / SINGLE_W;
  localparam int unsigned LPR16 = REG_W / HALF_W;
  localparam int unsigned LPR32 = REG_W / SINGLE_W;

  logic             undef;
  logic             is_half;
  logic [NL16-1:0]  en16;
  logic [NL32-1:0]  en32;
  logic [VEC_W-1:0] d16, d32, res_vec;
  logic             inv16, inx16, inv32, inx32;
  logic             res_inv, res_inx;
  logic             accept;

  pfc_decode #(.IDX_W(IDX_W)) u_dec (
    .size    (in_size),
    .half_ok (half_ok),
    .wide    (in_wide),
    .dst_idx (in_dst_idx),
    .src_idx (in_src_idx),
    .undef   (undef),
    .is_half (is_half)
  );

  for (genvar i = 0; i < NL16; i++) begin : g_en16
    assign en16[i] = !undef && is_half && ((i < LPR16) ? 1'b1 : in_wide);
  end
  for (genvar i = 0; i < NL32; i++) begin : g_en32
    assign en32[i] = !undef && !is_half && ((i < LPR32) ? 1'b1 : in_wide);
  end

  pfc_lane_array #(.IW(HALF_W), .EW(HALF_EW), .MW(HALF_MW), .NL(NL16)) u_half (
    .src (in_vec),
    .en  (en16),
    .uns (in_uns),
    .dst (d16),
    .inv (inv16),
    .inx (inx16)
  );

  pfc_lane_array #(.IW(SINGLE_W), .EW(SINGLE_EW), .MW(SINGLE_MW), .NL(NL32)) u_single (
    .src (in_vec),
    .en  (en32),
    .uns (in_uns),
    .dst (d32),
    .inv (inv32),
    .inx (inx32)
  );

  always_comb begin
    if (undef) begin
      res_vec = '0;
      res_inv = 1'b0;
      res_inx = 1'b0;
    end else if (is_half) begin
      res_vec = d16;
      res_inv = inv16;
      res_inx = inx16;
    end else begin
      res_vec = d32;
      res_inv = inv32;
      res_inx = inx32;
    end
  end

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_vec     <= '0;
      out_undef   <= 1'b0;
      out_invalid <= 1'b0;
      out_inexact <= 1'b0;
    end else if (accept) begin
      out_valid   <= 1'b1;
      out_vec     <= res_vec;
      out_undef   <= undef;
      out_invalid <= res_inv;
      out_inexact <= res_inx;
    end else if (out_ready) begin
      out_valid   <= 1'b0;
    end
  end
endmodule

// File: rtl/pfc_floor_chk.sv
module pfc_floor_chk #(
  parameter int unsigned REG_W = 64,
  parameter int unsigned IDX_W = 5
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic               in_ready,
  input logic [1:0]         in_size,
  input logic               in_wide,
  input logic               out_valid,
  input logic               out_ready,
  input logic [2*REG_W-1:0] out_vec,
  input logic               out_undef,
  input logic               out_invalid,
  input logic               out_inexact
);
  // R10
  ready_when_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  // R10
  accept_to_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  // R10
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_vec) && $stable(out_undef)
                                   && $stable(out_invalid) && $stable(out_inexact)));

  // R3
  undef_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_undef) |-> (out_vec == '0 && !out_invalid && !out_inexact));

  // R3
  rsv_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && (in_size == 2'b00 || in_size == 2'b11)) |=> out_undef);

  // R9
  narrow_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !in_wide) |=> (out_vec[2*REG_W-1:REG_W] == '0));
endmodule

bind pfc_floor_top pfc_floor_chk #(.REG_W(REG_W), .IDX_W(IDX_W)) u_chk (.*);

// File: tb/sim_pfc_floor_top.sv
module sim_pfc_floor_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         half_ok = 1'b1;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [127:0] in_vec = '0;
  logic [1:0]   in_size = 2'b10;
  logic         in_uns = 1'b0;
  logic         in_wide = 1'b0;
  logic [4:0]   in_dst_idx = '0;
  logic [4:0]   in_src_idx = '0;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic [127:0] out_vec;
  logic         out_undef, out_invalid, out_inexact;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;
  int rdy_pct = 100;

  logic [127:0] q_vec[$];
  bit           q_und[$];
  bit           q_inv[$];
  bit           q_inx[$];
  string        q_tag[$];

  always #5 clk = ~clk;

  pfc_floor_top u0 (
    .clk(clk), .rst_n(rst_n), .half_ok(half_ok),
    .in_valid(in_valid), .in_ready(in_ready), .in_vec(in_vec), .in_size(in_size),
    .in_uns(in_uns), .in_wide(in_wide), .in_dst_idx(in_dst_idx), .in_src_idx(in_src_idx),
    .out_valid(out_valid), .out_ready(out_ready), .out_vec(out_vec),
    .out_undef(out_undef), .out_invalid(out_invalid), .out_inexact(out_inexact)
  );

  function automatic logic [31:0] ref_lane(input logic [31:0] b, input int iw, input bit uns,
                                           output bit inv, output bit inx);
    int ew, mw, bias, e;
    longint m;
    bit s;
    real v, fl, lo, hi;
    ew = (iw == 16) ? 5 : 8;
    mw = (iw == 16) ? 10 : 23;
    bias = (1 << (ew - 1)) - 1;
    s = b[iw-1];
    e = int'((b >> mw) & ((32'd1 << ew) - 1));
    m = longint'(b & ((32'd1 << mw) - 1));
    inv = 1'b0;
    inx = 1'b0;
    lo = uns ? 0.0 : -(2.0 ** (iw - 1));
    hi = uns ? (2.0 ** iw) - 1.0 : (2.0 ** (iw - 1)) - 1.0;
    if (e == (1 << ew) - 1) begin
      if (m != 0) begin
        inv = 1'b1;
        return 32'd0;
      end
      fl = s ? lo - 1.0 : hi + 1.0;
      v = fl;
    end else if (e == 0) begin
      return 32'd0;
    end else begin
      v = (1.0 + real'(m) / (2.0 ** mw)) * (2.0 ** (e - bias));
      if (s) v = -v;
      fl = $floor(v);
    end
    if (fl < lo) begin
      inv = 1'b1;
      fl = lo;
    end else if (fl > hi) begin
      inv = 1'b1;
      fl = hi;
    end else begin
      inx = (fl != v);
    end
    return 32'(longint'(fl));
  endfunction

  task automatic ref_op(input logic [127:0] vec, input logic [1:0] sz, input bit uns,
                        input bit wide, input logic [4:0] di, input logic [4:0] si, input bit hok,
                        output logic [127:0] vo, output bit und, output bit inv, output bit inx);
    int iw, nl;
    logic [31:0] mask, lane, r;
    bit li, lx;
    vo = '0;
    inv = 1'b0;
    inx = 1'b0;
    und = (sz == 2'b00) || (sz == 2'b11) || (sz == 2'b01 && !hok) || (wide && (di[0] || si[0]));
    if (und) return;
    iw = (sz == 2'b01) ? 16 : 32;
    nl = (wide ? 128 : 64) / iw;
    mask = (iw == 16) ? 32'h0000_FFFF : 32'hFFFF_FFFF;
    for (int l = 0; l < nl; l++) begin
      lane = 32'(vec >> (l * iw)) & mask;
      r = ref_lane(lane, iw, uns, li, lx) & mask;
      vo = vo | (128'(r) << (l * iw));
      inv = inv | li;
      inx = inx | lx;
    end
  endtask

  task automatic step(output bit acc, input string tag);
    logic [127:0] ev;
    bit eu, ei, ex;
    #1;
    if (out_valid && out_ready) begin
      n_cmp++;
      if (q_vec.size() == 0) begin
        n_bad++;
        $display("FAIL R10: unexpected result actual=%h expected=none", out_vec);
      end else begin
        if (out_vec !== q_vec[0] || out_undef !== q_und[0] || out_invalid !== q_inv[0]
            || out_inexact !== q_inx[0]) begin
          n_bad++;
          $display("FAIL %s: actual vec=%h und=%b inv=%b inx=%b expected vec=%h und=%b inv=%b inx=%b",
                   q_tag[0], out_vec, out_undef, out_invalid, out_inexact,
                   q_vec[0], q_und[0], q_inv[0], q_inx[0]);
        end
        void'(q_vec.pop_front()); void'(q_und.pop_front()); void'(q_inv.pop_front());
        void'(q_inx.pop_front()); void'(q_tag.pop_front());
      end
    end
    acc = in_valid && in_ready;
    if (acc) begin
      ref_op(in_vec, in_size, in_uns, in_wide, in_dst_idx, in_src_idx, half_ok, ev, eu, ei, ex);
      q_vec.push_back(ev); q_und.push_back(eu); q_inv.push_back(ei);
      q_inx.push_back(ex); q_tag.push_back(tag);
    end
    @(negedge clk);
    out_ready = (($urandom % 100) < rdy_pct);
  endtask

  task automatic send(input logic [127:0] v, input logic [1:0] sz, input bit uns, input bit wide,
                      input logic [4:0] di, input logic [4:0] si, input string tag);
    bit acc;
    in_vec = v; in_size = sz; in_uns = uns; in_wide = wide;
    in_dst_idx = di; in_src_idx = si; in_valid = 1'b1;
    do step(acc, tag); while (!acc);
    in_valid = 1'b0;
  endtask

  task automatic drain();
    bit acc;
    rdy_pct = 100;
    for (int k = 0; k < 8; k++) step(acc, "R10");
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_bad++;
      $display("FAIL R10: watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    n_cmp++;
    if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
      n_bad++;
      $display("FAIL R11: in reset actual valid=%b ready=%b expected valid=0 ready=1", out_valid, in_ready);
    end
    rst_n = 1'b1;
    @(negedge clk);
    n_cmp++;
    if (out_valid !== 1'b0) begin
      n_bad++;
      $display("FAIL R11: after reset actual valid=%b expected 0", out_valid);
    end

    // R1 floor of half lanes, signed
    send({64'h0, 16'h4000, 16'hB800, 16'hBE00, 16'h3E00}, 2'b01, 1'b0, 1'b0, 5'd2, 5'd4, "R1");
    // R4 same lanes unsigned
    send({64'h0, 16'h4000, 16'hB800, 16'hBE00, 16'h3E00}, 2'b01, 1'b1, 1'b0, 5'd2, 5'd4, "R4");
    // R5 half saturation and infinities
    send({64'h0, 16'h3C00, 16'hFC00, 16'h7C00, 16'h7BFF}, 2'b01, 1'b0, 1'b0, 5'd0, 5'd0, "R5");
    send({64'h0, 16'h3C00, 16'hFC00, 16'h7C00, 16'h7BFF}, 2'b01, 1'b1, 1'b0, 5'd0, 5'd0, "R5");
    // R5 single limits
    send({64'h0, 32'hCF00_0000, 32'h4F00_0000}, 2'b10, 1'b0, 1'b0, 5'd1, 5'd3, "R5");
    send({64'h0, 32'h5015_02F9, 32'h4F00_0000}, 2'b10, 1'b1, 1'b0, 5'd1, 5'd3, "R5");
    // R6 NaN
    send({64'h0, 32'h7FC0_0000, 32'h4000_0000}, 2'b10, 1'b0, 1'b0, 5'd0, 5'd0, "R6");
    // R7 zeros and denormals
    send({64'h0, 16'h0000, 16'h83FF, 16'h8000, 16'h0001}, 2'b01, 1'b0, 1'b0, 5'd0, 5'd0, "R7");
    // R8 exact vs inexact single
    send({64'h0, 32'hC040_0000, 32'h4000_0000}, 2'b10, 1'b0, 1'b0, 5'd0, 5'd0, "R8");
    send({64'h0, 32'hC070_0000, 32'h4070_0000}, 2'b10, 1'b0, 1'b0, 5'd0, 5'd0, "R8");
    // R2 / R9 wide and narrow with upper data present
    send({32'hC0A0_0000, 32'h4120_0000, 32'h3F40_0000, 32'hBF40_0000}, 2'b10, 1'b0, 1'b1, 5'd2, 5'd6, "R2");
    send({32'hC0A0_0000, 32'h4120_0000, 32'h3F40_0000, 32'hBF40_0000}, 2'b10, 1'b0, 1'b0, 5'd2, 5'd6, "R9");
    send({16'h4500, 16'hC500, 16'h3555, 16'h4900, 64'h0}, 2'b01, 1'b0, 1'b1, 5'd0, 5'd0, "R2");
    // R3 illegal encodings
    send({4{32'h4070_0000}}, 2'b00, 1'b0, 1'b0, 5'd0, 5'd0, "R3");
    send({4{32'h4070_0000}}, 2'b11, 1'b0, 1'b0, 5'd0, 5'd0, "R3");
    send({4{32'h4070_0000}}, 2'b10, 1'b0, 1'b1, 5'd3, 5'd0, "R3");
    send({4{32'h4070_0000}}, 2'b10, 1'b0, 1'b1, 5'd0, 5'd5, "R3");
    half_ok = 1'b0;
    send({8{16'h3E00}}, 2'b01, 1'b0, 1'b0, 5'd0, 5'd0, "R3");
    half_ok = 1'b1;
    drain();

    // R10 back-pressure with random stalls and random traffic
    rdy_pct = 40;
    for (int n = 0; n < 400; n++) begin
      half_ok = ($urandom % 8) != 0;
      send({$urandom, $urandom, $urandom, $urandom}, 2'($urandom % 4), 1'($urandom),
           1'($urandom), 5'($urandom), 5'($urandom), "R10");
    end
    drain();

    n_cmp++;
    if (q_vec.size() != 0) begin
      n_bad++;
      $display("FAIL R10: pending results actual=%0d expected=0", q_vec.size());
    end
    done = 1'b1;
    summary();
    $finish;
  end
endmodule